// File: doc/BRIEF.md
# Multi-Agent Exclusive Reservation Monitor

This block is the shared side of a load-linked / store-conditional scheme for several requesting agents. Each agent owns one reservation entry. An entry holds an armed/idle flag and the full address tagged by that agent's last load-linked. Requests arrive one per cycle, each tagged with the ID of the agent that sent it. Four kinds are accepted: load-linked, ordinary store, store-conditional, and detach. For every store-conditional the block returns a verdict one cycle later. It also returns the commit decision that gates the memory write. That decision combines the block's own verdict with the agent's local-monitor verdict, which arrives alongside the request.

Hardware exclusives can fail now and then with no visible cause. To model this, each agent has a failure counter that forces one otherwise-valid store-conditional to fail at a fixed interval. When an agent's check passes globally, the block drops peer reservations that fall in the same coarse address region. This is deliberately more conservative than an exact compare. A store-conditional that commits counts as a store, so it drops every reservation.

Top module: `resv_monitor`

## Requirements
- R1: Request codes on `req_op` are 2'b00 load-linked, 2'b01 store, 2'b10 store-conditional and 2'b11 detach. A load-linked makes its agent active and arms the agent's entry with the exact `req_addr`. The change takes effect at the clock edge that samples the request.
- R2: A detach makes its agent inactive and idle. A store-conditional from an inactive agent always fails, and it changes no entry and no counter.
- R3: An ordinary store from any agent disarms every armed entry.
- R4: The global check of a store-conditional matches only if the requester is active and armed and its tag equals all bits of `req_addr`. A tag mismatch fails and leaves the requester's entry armed.
- R5: A check that matches disarms the requester's entry, whether it then passes or is forced to fail.
- R6: Each agent's failure counter starts at zero and rises by one on each matching check. When a matching check finds the counter at MAX_FAIL (default 5), the check fails and the counter returns to zero. With the default, every sixth matching check fails. Detach does not touch the counter.
- R7: When the global check passes, every other agent whose armed tag equals `req_addr` under REGION_MASK (default: bits 31..6, 64-byte regions) is disarmed. This happens even if the local verdict is low. Other agents' entries outside that region stay armed.
- R8: `rsp_commit` is high only when the global check passes and `req_local_ok` is high. A commit acts as a store and disarms every entry.
- R9: `rsp_valid` is high for exactly the one cycle after a store-conditional is sampled and low after any other request. `rsp_global_ok` and `rsp_commit` are low whenever `rsp_valid` is low.
- R10: While `rst_n` is low, requests are ignored. After reset all agents are inactive and idle, all counters are zero, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | Request code (see R1) |
| req_agent | input | AGENT_W (2) | ID of the requesting agent |
| req_addr | input | ADDR_W (32) | Request address |
| req_local_ok | input | 1 | Local-monitor verdict for a store-conditional |
| rsp_valid | output | 1 | Store-conditional verdict is present |
| rsp_global_ok | output | 1 | Global check passed |
| rsp_commit | output | 1 | Write may proceed; success value returned to the agent |

## Verification
Every entry and counter update lands on the rising edge that samples the request. So a following request sees the new state, and the three response outputs are due exactly one rising edge after a store-conditional. The bench drives each request on a falling edge, samples the responses on the next falling edge, and then deasserts the request. All entry effects (arming, peer drops, store drops, forced failures) are checked through the verdicts of later store-conditionals, compared against a bench reference model.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic [1:0] {
    OP_LL     = 2'b00,
    OP_STORE  = 2'b01,
    OP_SC     = 2'b10,
    OP_DETACH = 2'b11
  } resv_op_e;

  // Two addresses fall in one coarse region when they agree on every mask bit.
  function automatic logic region_eq(input logic [63:0] a,
                                     input logic [63:0] b,
                                     input logic [63:0] mask);
    return ((a ^ b) & mask) == 64'd0;
  endfunction

  // A matching check is forced to fail once the counter has reached the limit.
  function automatic logic fail_due(input int unsigned cnt,
                                    input int unsigned limit);
    return cnt >= limit;
  endfunction

endpackage

// File: rtl/resv_entry.sv
module resv_entry #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ll_set,
  input  logic [ADDR_W-1:0] ll_addr,
  input  logic              wipe,
  input  logic              drop,
  output logic              is_active,
  output logic              is_rmw,
  output logic [ADDR_W-1:0] tag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_active <= 1'b0;
      is_rmw    <= 1'b0;
      tag       <= '0;
    end else if (drop) begin
      is_active <= 1'b0;
      is_rmw    <= 1'b0;
      tag       <= '0;
    end else if (ll_set) begin
      is_active <= 1'b1;
      is_rmw    <= 1'b1;
      tag       <= ll_addr;
    end else if (wipe) begin
      is_rmw    <= 1'b0;
      tag       <= '0;
    end
  end

  assert_ll_arms_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ll_set && !drop) |=> (is_active && is_rmw && tag == $past(ll_addr)));

  assert_idle_when_inactive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !is_active |-> !is_rmw);

  assert_drop_idles_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (!is_active && !is_rmw));

endmodule

// File: rtl/resv_fail_ctr.sv
module resv_fail_ctr
  import resv_pkg::*;
#(
  parameter int MAX_FAIL = 5,
  localparam int CNT_W = $clog2(MAX_FAIL + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bump,
  output logic force_fail
);

  logic [CNT_W-1:0] cnt;

  assign force_fail = fail_due(int'(cnt), MAX_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (bump) begin
      if (force_fail) cnt <= '0;
      else            cnt <= cnt + CNT_W'(1);
    end
  end

  assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bump && force_fail) |=> (cnt == '0));

  assert_count_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= MAX_FAIL);

  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !bump |=> $stable(cnt));

endmodule

// File: rtl/resv_resp.sv
module resv_resp (
  input  logic clk,
  input  logic rst_n,
  input  logic sc_fire,
  input  logic glob_ok,
  input  logic commit,
  output logic rsp_valid,
  output logic rsp_global_ok,
  output logic rsp_commit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_global_ok <= 1'b0;
      rsp_commit    <= 1'b0;
    end else begin
      rsp_valid     <= sc_fire;
      rsp_global_ok <= sc_fire && glob_ok;
      rsp_commit    <= sc_fire && commit;
    end
  end

  assert_commit_needs_global_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_commit |-> rsp_global_ok);

  assert_quiet_without_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_global_ok && !rsp_commit));

endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int N_AGENTS = 4,
  parameter int ADDR_W   = 32,
  parameter int MAX_FAIL = 5,
  parameter logic [ADDR_W-1:0] REGION_MASK = {{(ADDR_W-6){1'b1}}, 6'b0},
  localparam int AGENT_W = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [1:0]         req_op,
  input  logic [AGENT_W-1:0] req_agent,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_local_ok,
  output logic               rsp_valid,
  output logic               rsp_global_ok,
  output logic               rsp_commit
);

  // Decoded request events.
  logic is_ll, is_store, is_sc, is_detach;
  assign is_ll     = req_valid && (req_op == OP_LL);
  assign is_store  = req_valid && (req_op == OP_STORE);
  assign is_sc     = req_valid && (req_op == OP_SC);
  assign is_detach = req_valid && (req_op == OP_DETACH);

  // Per-agent state brought out of the entries and counters.
  logic [N_AGENTS-1:0] act_vec;
  logic [N_AGENTS-1:0] rmw_vec;
  logic [N_AGENTS-1:0] force_vec;
  logic [ADDR_W-1:0]   tag_arr [N_AGENTS];

  // Requester's view.
  logic agent_ok;
  logic sel_active;
  logic chk_hit;
  logic glob_ok;
  logic commit;

  assign agent_ok   = int'(req_agent) < N_AGENTS;
  assign sel_active = agent_ok && act_vec[req_agent];
  assign chk_hit    = is_sc && sel_active && rmw_vec[req_agent]
                      && (tag_arr[req_agent] == req_addr);
  assign glob_ok    = chk_hit && !force_vec[req_agent];
  assign commit     = glob_ok && req_local_ok;

  for (genvar i = 0; i < N_AGENTS; i++) begin : g_agent
    logic is_me;
    logic ll_set, drop, bump, peer_hit, wipe;

    assign is_me    = (req_agent == AGENT_W'(i));
    assign ll_set   = is_ll && is_me;
    assign drop     = is_detach && is_me;
    assign bump     = chk_hit && is_me;
    assign peer_hit = glob_ok && !is_me
                      && region_eq(64'(tag_arr[i]), 64'(req_addr), 64'(REGION_MASK));
    assign wipe     = is_store || commit || bump || peer_hit;

    resv_entry #(.ADDR_W(ADDR_W)) i_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .ll_set    (ll_set),
      .ll_addr   (req_addr),
      .wipe      (wipe),
      .drop      (drop),
      .is_active (act_vec[i]),
      .is_rmw    (rmw_vec[i]),
      .tag       (tag_arr[i])
    );

    resv_fail_ctr #(.MAX_FAIL(MAX_FAIL)) i_fail_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .bump       (bump),
      .force_fail (force_vec[i])
    );

    assert_peer_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
      peer_hit |=> !rmw_vec[i]);

    assert_match_disarms_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bump |=> !rmw_vec[i]);
  end

  resv_resp i_resp (
    .clk           (clk),
    .rst_n         (rst_n),
    .sc_fire       (is_sc),
    .glob_ok       (glob_ok),
    .commit        (commit),
    .rsp_valid     (rsp_valid),
    .rsp_global_ok (rsp_global_ok),
    .rsp_commit    (rsp_commit)
  );

  assert_store_clears_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    is_store |=> (rmw_vec == '0));

  assert_commit_clears_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sc && commit) |=> (rmw_vec == '0));

  assert_inactive_sc_fails_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sc && !sel_active) |=> (rsp_valid && !rsp_global_ok));

  assert_rsp_follows_sc_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_sc |=> rsp_valid);

  assert_rsp_idle_otherwise_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !is_sc |=> !rsp_valid);

endmodule

// File: tb/test_resv_monitor.sv
module test_resv_monitor;

  localparam int CLK_PERIOD = 10;
  localparam int NA         = 4;
  localparam int MAXF       = 5;
  localparam logic [31:0] RMASK = 32'hFFFF_FFC0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'b00;
  logic [1:0]  req_agent = 2'b00;
  logic [31:0] req_addr = 32'h0;
  logic        req_local_ok = 1'b0;
  logic        rsp_valid, rsp_global_ok, rsp_commit;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Reference model state.
  bit          m_act [NA];
  bit          m_rmw [NA];
  logic [31:0] m_tag [NA];
  int          m_cnt [NA];

  always #(CLK_PERIOD/2) clk = ~clk;

  resv_monitor i_resv_monitor (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_op        (req_op),
    .req_agent     (req_agent),
    .req_addr      (req_addr),
    .req_local_ok  (req_local_ok),
    .rsp_valid     (rsp_valid),
    .rsp_global_ok (rsp_global_ok),
    .rsp_commit    (rsp_commit)
  );

  task automatic chk(input string rq, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got valid/global/commit=%b expected=%b", rq, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NA; i++) begin
      m_act[i] = 1'b0; m_rmw[i] = 1'b0; m_tag[i] = 32'h0; m_cnt[i] = 0;
    end
  endtask

  // Applies one request to the model and returns the expected response bits.
  function automatic logic [2:0] model_step(input logic [1:0] op, input int ag,
                                            input logic [31:0] ad, input logic lo);
    logic g, c;
    g = 1'b0; c = 1'b0;
    case (op)
      2'b00: begin m_act[ag] = 1'b1; m_rmw[ag] = 1'b1; m_tag[ag] = ad; end
      2'b01: for (int j = 0; j < NA; j++) m_rmw[j] = 1'b0;
      2'b11: begin m_act[ag] = 1'b0; m_rmw[ag] = 1'b0; end
      default: begin
        if (m_act[ag] && m_rmw[ag] && m_tag[ag] == ad) begin
          m_rmw[ag] = 1'b0;
          if (m_cnt[ag] >= MAXF) m_cnt[ag] = 0;
          else begin m_cnt[ag] = m_cnt[ag] + 1; g = 1'b1; end
        end
        if (g)
          for (int j = 0; j < NA; j++)
            if (j != ag && m_act[j] && m_rmw[j] && ((m_tag[j] ^ ad) & RMASK) == 32'h0)
              m_rmw[j] = 1'b0;
        c = g && lo;
        if (c) for (int j = 0; j < NA; j++) m_rmw[j] = 1'b0;
      end
    endcase
    return {(op == 2'b10), g, c};
  endfunction

  task automatic issue(input logic [1:0] op, input int ag, input logic [31:0] ad,
                       input logic lo, input string rq);
    logic [2:0] exp;
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_agent = 2'(ag); req_addr = ad; req_local_ok = lo;
    exp = model_step(op, ag, ad, lo);
    @(negedge clk);
    chk(rq, {rsp_valid, rsp_global_ok, rsp_commit}, exp);
    req_valid = 1'b0;
  endtask

  task automatic expect_sc(input int ag, input logic [31:0] ad, input logic lo,
                           input logic [2:0] exp, input string rq);
    logic [2:0] mdl;
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b10; req_agent = 2'(ag); req_addr = ad; req_local_ok = lo;
    mdl = model_step(2'b10, ag, ad, lo);
    @(negedge clk);
    chk(rq, {rsp_valid, rsp_global_ok, rsp_commit}, exp);
    chk({rq, " model"}, mdl, exp);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [31:0] A = 32'h1000_0040;
  localparam logic [31:0] B = 32'h1000_0100;
  localparam logic [31:0] C = 32'h2000_0000;

  initial begin
    model_reset();
    // R10: a request held during reset is ignored.
    @(negedge clk);
    req_valid = 1'b1; req_op = 2'b00; req_agent = 2'd1; req_addr = A; req_local_ok = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    chk("R10 outputs low in reset", {rsp_valid, rsp_global_ok, rsp_commit}, 3'b000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R10 outputs low after reset", {rsp_valid, rsp_global_ok, rsp_commit}, 3'b000);
    expect_sc(1, A, 1'b1, 3'b100, "R10 LL during reset ignored");
    expect_sc(0, A, 1'b1, 3'b100, "R2 SC from never-active agent");

    // R1 / R4 / R5: exact match, mismatch keeps entry, match clears it.
    issue(2'b00, 0, A, 1'b0, "R9 LL gives no response");
    expect_sc(0, A + 32'd4, 1'b1, 3'b100, "R4 address mismatch fails");
    expect_sc(0, A, 1'b1, 3'b111, "R1 R4 exact match commits");
    expect_sc(0, A, 1'b1, 3'b100, "R5 entry cleared after match");

    // R6: every sixth matching check fails (agent 2 fresh).
    for (int k = 0; k < 6; k++) begin
      issue(2'b00, 2, B, 1'b0, "R1 LL agent2");
      if (k < 5) expect_sc(2, B, 1'b1, 3'b111, "R6 pass before limit");
      else       expect_sc(2, B, 1'b1, 3'b100, "R6 forced failure at limit");
    end
    expect_sc(2, B, 1'b1, 3'b100, "R5 forced failure still clears entry");
    issue(2'b00, 2, B, 1'b0, "R1 LL agent2");
    expect_sc(2, B, 1'b1, 3'b111, "R6 counter wrapped to zero");

    // R7: peer in same 64-byte region dropped, other region kept, local fail.
    issue(2'b00, 1, A, 1'b0, "R1 LL agent1");
    issue(2'b00, 3, A + 32'd8, 1'b0, "R1 LL agent3");
    issue(2'b00, 0, B, 1'b0, "R1 LL agent0");
    expect_sc(1, A, 1'b0, 3'b110, "R8 global pass local fail no commit");
    expect_sc(3, A + 32'd8, 1'b1, 3'b100, "R7 same-region peer dropped");
    expect_sc(0, B, 1'b1, 3'b111, "R7 other-region peer kept");

    // R8: a commit behaves as a store for everyone.
    issue(2'b00, 0, B, 1'b0, "R1 LL agent0");
    issue(2'b00, 1, C, 1'b0, "R1 LL agent1");
    expect_sc(0, B, 1'b1, 3'b111, "R8 commit");
    expect_sc(1, C, 1'b1, 3'b100, "R8 commit cleared far reservation");

    // R3: ordinary store drops all reservations.
    issue(2'b00, 0, A, 1'b0, "R1 LL agent0");
    issue(2'b00, 3, C, 1'b0, "R1 LL agent3");
    issue(2'b01, 2, 32'h3000_0000, 1'b0, "R9 store gives no response");
    expect_sc(0, A, 1'b1, 3'b100, "R3 store dropped agent0");
    expect_sc(3, C, 1'b1, 3'b100, "R3 store dropped agent3");

    // R2: detach, then re-join.
    issue(2'b00, 3, C, 1'b0, "R1 LL agent3");
    issue(2'b11, 3, 32'h0, 1'b0, "R9 detach gives no response");
    expect_sc(3, C, 1'b1, 3'b100, "R2 detached agent fails");
    issue(2'b00, 3, C, 1'b0, "R1 LL agent3 rejoin");
    expect_sc(3, C, 1'b1, 3'b111, "R2 rejoined agent passes");

    // Constrained random mix checked against the model.
    void'($urandom(32'd2024));
    for (int n = 0; n < 400; n++) begin
      int r, ag;
      logic [1:0] op;
      logic [31:0] ad;
      r  = int'($urandom % 10);
      ag = int'($urandom % NA);
      ad = 32'h1000_0000 + 32'($urandom % 3) * 32'd64 + 32'($urandom % 2) * 32'd4;
      if (r < 4)       op = 2'b00;
      else if (r == 4) op = 2'b01;
      else if (r < 9)  op = 2'b10;
      else             op = 2'b11;
      issue(op, ag, ad, ($urandom % 4) != 0, "R1-mix random R4 R6 R7 R8 R9");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule